// File: doc/BRIEF.md
# Timer Compare and PWM Channel

This block is one timer channel that owns its own counter and produces a single reference waveform. The counter either runs upward and wraps after reaching the reload value, or runs up to the reload value and back down to zero for center-aligned operation. A compare value is checked against the count on every enabled cycle. A 3-bit mode field then decides what happens to the reference. It can be set, cleared or toggled on a match, or it can be produced as a PWM level of either polarity.

Two pulses come out beside the reference. One marks the counter turning points (wrap or direction change). The other marks every cycle in which the count equals the compare value. The block is meant to sit behind register logic that supplies the reload value, compare value, mode and alignment directly. No prescaling, shadowing or dead time is applied here.

Top module: `pwm_compare_channel`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the count to 0, sets the count direction to upward and drives `ref_out` low.
- R2: With `center_sel` low and `en` high, the count advances by one per cycle. When the count is at or above `reload`, the next count is 0 instead. `ovf_pulse` is high in each enabled cycle whose count is at or above `reload`, so it repeats every `reload`+1 cycles.
- R3: With `center_sel` high and `en` high, the count goes up from 0 to `reload` and then down to 0, repeating with a period of 2×`reload` cycles. `ovf_pulse` is high at the top (count at or above `reload` while going up) and at the bottom (count 0 while going down). When `reload` is 0 the count stays at 0 and `ovf_pulse` is high every enabled cycle.
- R4: `match_pulse` is high in every cycle in which `en` is high and the count equals `cmp`, whatever the mode.
- R5: The compare modes are 3'b001 (set `ref_out` high on a match), 3'b010 (clear `ref_out` on a match) and 3'b011 (invert `ref_out` on a match). `ref_out` changes at the rising edge that ends the matching cycle.
- R6: The codes 3'b000, 3'b100 and 3'b101 leave `ref_out` unchanged.
- R7: When `cmp` is not above `reload`, code 3'b110 makes `ref_out` high after each enabled edge whose count was below `cmp`, and low otherwise. Code 3'b111 gives the exact inverse. This applies in both count directions.
- R8: When `cmp` is above `reload`, code 3'b110 drives `ref_out` low and code 3'b111 drives it high on every enabled edge.
- R9: While `en` is low, the count, the direction and `ref_out` keep their values, and both pulses stay low.
- R10: If `reload` is lowered below the current count, the count is treated as having reached the top on the next enabled edge. In edge-aligned operation it wraps to 0. In center-aligned operation it turns down starting from `reload`−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counter enable |
| center_sel | input | 1 | 1 = up/down (center-aligned), 0 = up only |
| reload | input | CNT_W | Top value of the count |
| cmp | input | CNT_W | Compare value |
| mode | input | 3 | Reference behaviour code |
| ref_out | output | 1 | Reference waveform |
| ovf_pulse | output | 1 | Turning-point strobe |
| match_pulse | output | 1 | Count-equals-compare strobe |

## Verification
The turning-point strobe and the compare strobe fall in the same cycle whenever `cmp` equals `reload`. In center-aligned operation they also coincide when `cmp` is 0 and the count reaches the bottom. A match-toggle can land on that same cycle. The sweep over every reload from 0 to 5, every compare value from 0 to 7, all eight mode codes and both alignments therefore reaches each coincidence many times. In every sampled cycle the bench compares both strobes and the reference against an independent arithmetic model, so a coincident cycle is judged like any other and is never masked.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD   = 3'b000,
    MODE_SET    = 3'b001,
    MODE_CLEAR  = 3'b010,
    MODE_TOGGLE = 3'b011,
    MODE_HOLD4  = 3'b100,
    MODE_HOLD5  = 3'b101,
    MODE_PWM_LO = 3'b110,
    MODE_PWM_HI = 3'b111
  } pcc_mode_e;
endpackage

// File: rtl/pcc_counter.sv
module pcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center_sel,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic             at_turn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic going_up;
  logic at_top;
  logic at_bottom;

  assign going_up  = !center_sel || up_q;
  assign at_top    = cnt_q >= reload;
  assign at_bottom = cnt_q == '0;
  assign at_turn   = going_up ? at_top : at_bottom;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en) begin
      if (!center_sel) begin
        up_q  <= 1'b1;
        cnt_q <= at_top ? '0 : cnt_q + ONE;
      end else if (up_q) begin
        if (at_top) begin
          if (reload == '0) begin
            cnt_q <= '0;
          end else begin
            up_q  <= 1'b0;
            cnt_q <= reload - ONE;
          end
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (at_bottom) begin
          up_q  <= 1'b1;
          cnt_q <= (reload == '0) ? '0 : ONE;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pcc_refgen.sv
module pcc_refgen
  import pcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] reload,
  input  logic             hit,
  output logic             ref_q
);
  function automatic logic pwm_level(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] cv,
                                     input logic [CNT_W-1:0] top,
                                     input logic             invert);
    logic lvl;
    if (cv > top) lvl = 1'b0;
    else          lvl = c < cv;
    return lvl ^ invert;
  endfunction

  logic ref_d;

  always_comb begin
    ref_d = ref_q;
    case (pcc_mode_e'(mode))
      MODE_SET:    if (hit) ref_d = 1'b1;
      MODE_CLEAR:  if (hit) ref_d = 1'b0;
      MODE_TOGGLE: if (hit) ref_d = !ref_q;
      MODE_PWM_LO: ref_d = pwm_level(cnt, cmp, reload, 1'b0);
      MODE_PWM_HI: ref_d = pwm_level(cnt, cmp, reload, 1'b1);
      default:     ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     ref_q <= 1'b0;
    else if (en) ref_q <= ref_d;
  end
endmodule

// File: rtl/pwm_compare_channel.sv
module pwm_compare_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center_sel,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp,
  input  logic [2:0]       mode,
  output logic             ref_out,
  output logic             ovf_pulse,
  output logic             match_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             at_turn;
  logic             hit;

  pcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .center_sel (center_sel),
    .reload     (reload),
    .cnt_q      (cnt_q),
    .up_q       (up_q),
    .at_turn    (at_turn)
  );

  assign hit = cnt_q == cmp;

  pcc_refgen #(.CNT_W(CNT_W)) u_ref (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .mode   (mode),
    .cnt    (cnt_q),
    .cmp    (cmp),
    .reload (reload),
    .hit    (hit),
    .ref_q  (ref_out)
  );

  assign ovf_pulse   = en && at_turn;
  assign match_pulse = en && hit;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             center_sel,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cmp,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] cnt_q,
  input logic             up_q,
  input logic             ref_out,
  input logic             ovf_pulse,
  input logic             match_pulse
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (cnt_q == '0) && up_q && !ref_out); // R1
  AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (rst) (en && !center_sel && ovf_pulse) |=> cnt_q == '0); // R2
  AST_CENTER_BOTTOM: assert property (@(posedge clk) disable iff (rst) (en && center_sel && !up_q && cnt_q == '0) |-> ovf_pulse); // R3
  AST_MATCH_STROBE: assert property (@(posedge clk) disable iff (rst) (en && cnt_q == cmp) |-> match_pulse); // R4
  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst) (mode == 3'b001 && match_pulse) |=> ref_out); // R5
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst) (mode == 3'b010 && match_pulse) |=> !ref_out); // R5
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (rst) (mode == 3'b011 && match_pulse) |=> ref_out != $past(ref_out)); // R5
  AST_FROZEN_CODE: assert property (@(posedge clk) disable iff (rst) (mode == 3'b000 || mode == 3'b100 || mode == 3'b101) |=> $stable(ref_out)); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst) (en && mode == 3'b110 && cmp > reload) |=> !ref_out); // R8
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst) (en && mode == 3'b111 && cmp > reload) |=> ref_out); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(cnt_q) && $stable(up_q) && $stable(ref_out)); // R9
  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst) !en |-> !ovf_pulse && !match_pulse); // R9
endmodule

bind pwm_compare_channel pcc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .center_sel  (center_sel),
  .reload      (reload),
  .cmp         (cmp),
  .mode        (mode),
  .cnt_q       (cnt_q),
  .up_q        (up_q),
  .ref_out     (ref_out),
  .ovf_pulse   (ovf_pulse),
  .match_pulse (match_pulse)
);

// File: tb/pwm_compare_channel_test.sv
module pwm_compare_channel_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         center_sel = 1'b0;
  logic [W-1:0] reload = '0;
  logic [W-1:0] cmp = '0;
  logic [2:0]   mode = 3'b000;
  logic         ref_out, ovf_pulse, match_pulse;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  logic [W-1:0] m_cnt = '0;
  logic         m_up = 1'b1;
  logic         m_ref = 1'b0;

  pwm_compare_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .center_sel(center_sel),
    .reload(reload), .cmp(cmp), .mode(mode),
    .ref_out(ref_out), .ovf_pulse(ovf_pulse), .match_pulse(match_pulse)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (R=%0d C=%0d mode=%0b ctr=%0b cnt=%0d)",
               tag, what, act, exp, reload, cmp, mode, center_sel, m_cnt);
    end
  endtask

  function automatic string ref_tag();
    if (!en) return "R9";
    if (mode == 3'b110 || mode == 3'b111) return (cmp > reload) ? "R8" : "R7";
    if (mode == 3'b001 || mode == 3'b010 || mode == 3'b011) return "R5";
    return "R6";
  endfunction

  // model advance for the coming rising edge, from current inputs
  task automatic model_step();
    logic top, lt;
    if (rst) begin
      m_cnt = '0; m_up = 1'b1; m_ref = 1'b0;
      return;
    end
    if (!en) return;
    lt = m_cnt < cmp;
    case (mode)
      3'b001: if (m_cnt == cmp) m_ref = 1'b1;
      3'b010: if (m_cnt == cmp) m_ref = 1'b0;
      3'b011: if (m_cnt == cmp) m_ref = !m_ref;
      3'b110: m_ref = (cmp > reload) ? 1'b0 : lt;
      3'b111: m_ref = (cmp > reload) ? 1'b1 : !lt;
      default: ;
    endcase
    top = m_cnt >= reload;
    if (!center_sel) begin
      m_up = 1'b1;
      m_cnt = top ? '0 : m_cnt + 1'b1;
    end else if (m_up) begin
      if (top) begin
        if (reload == 0) m_cnt = '0;
        else begin m_up = 1'b0; m_cnt = reload - 1'b1; end
      end else m_cnt = m_cnt + 1'b1;
    end else begin
      if (m_cnt == 0) begin m_up = 1'b1; m_cnt = (reload == 0) ? '0 : W'(1); end
      else m_cnt = m_cnt - 1'b1;
    end
  endtask

  task automatic tick(input string cnt_tag);
    logic e_ovf, e_match;
    model_step();
    @(posedge clk);
    @(negedge clk);
    if (rst) return;
    if (!en) begin
      e_ovf = 1'b0;
    end else if (!center_sel || m_up) e_ovf = m_cnt >= reload;
    else e_ovf = m_cnt == 0;
    e_match = en && (m_cnt == cmp);
    chk(en ? cnt_tag : "R9", "ovf_pulse", ovf_pulse, e_ovf);
    chk(en ? "R4" : "R9", "match_pulse", match_pulse, e_match);
    chk(ref_tag(), "ref_out", ref_out, m_ref);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick("R1");
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    en = 1'b0; do_reset();
    chk("R1", "ref_out after reset", ref_out, 1'b0);
    chk("R1", "ovf idle after reset", ovf_pulse, 1'b0);

    // sweep: edge (R2) and center (R3) over reload, compare and all modes
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 6; r++) begin
        for (int k = 0; k < 8; k++) begin
          for (int m = 0; m < 8; m++) begin
            center_sel = c[0]; reload = r[W-1:0]; cmp = k[W-1:0]; mode = m[2:0];
            en = 1'b0;
            do_reset();
            for (int i = 0; i < 26; i++) begin
              en = !(i >= 9 && i < 12);   // R9 idle window
              tick(c ? "R3" : "R2");
            end
          end
        end
      end
    end

    // R10: reload lowered below a running count
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 8; m++) begin
        center_sel = c[0]; reload = 4'd7; cmp = 4'd1; mode = m[2:0]; en = 1'b0;
        do_reset();
        en = 1'b1;
        for (int i = 0; i < 5; i++) tick(c ? "R3" : "R2");
        reload = 4'd2;
        for (int i = 0; i < 12; i++) tick("R10");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule